// File: doc/BRIEF.md
# Capture-Reload Timer Channel

This block is a single up-counting timer channel with two capture inputs. A strobe on either input records the counter value of that cycle into a small first-in first-out store kept for that input. Software reads each store through a pop strobe and sees how many words it holds. A two-bit selector lets a capture event also reload the counter from a load value, for capture 1, capture 2 or either one. This gives period measurement that restarts at each edge.

The channel has one output flag, which toggles each time the counter wraps. The flag passes through a polarity inverter to the output pin, and an output enable goes with it. A two-bit debug field acts while the chip is in debug mode. One bit freezes the counter. The other bit drives the flag low before the inverter, so an inverted pin still shows 1. A stop-mode bit can drop the output enable while the chip is stopped. Four sticky status flags record counter wrap, each capture, and reloads. Each flag is cleared by writing 1 to it.

Top module: `caprl_timer_chan`

## Requirements
- R1: After synchronous reset the counter, both FIFO word counts, both FIFO read words, all status bits and the internal flag are 0. The pin then equals the invert input.
- R2: When count_en is 1 and the counter is not halted, the counter rises by one per clock. When count_en is 0 it holds.
- R3: An increment from the all-ones value wraps the counter to 0, sets status bit 0 and toggles the flag.
- R4: A capture strobe pushes the counter value of the strobe cycle into that input's FIFO and sets status bit 1 (capture 1) or bit 2 (capture 2). The other FIFO is not touched.
- R5: Each FIFO holds DEPTH words (2 by default), and its count output gives the number held. A strobe that arrives while the FIFO is full is dropped, even if a pop happens in the same cycle.
- R6: A pop returns the oldest word first and lowers the count by one. The read word is 0 while the FIFO is empty, and a pop on an empty FIFO has no effect.
- R7: reload_sel sets which captures reload the counter: 00 none, 01 capture 1, 10 capture 2, 11 either. On the next clock the counter equals load_val, and a reload overrides counting.
- R8: When a capture and a reload fall in the same cycle, the FIFO receives the value the counter had before the reload.
- R9: Every reload sets status bit 3.
- R10: With dbg_mode high, dbg_ctl bit 0 halts the counter. dbg_ctl 00 leaves operation unchanged.
- R11: With dbg_mode high and dbg_ctl bit 1 set, the flag is forced to 0 ahead of the inverter, so the pin equals out_invert.
- R12: out_oe is out_enable, except that it is 0 while stop_mode and stop_oe_off are both 1.
- R13: Writing 1 to a bit of sts_clr clears that status bit. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Count clock enable |
| cap1_strobe | input | 1 | Capture 1 event |
| cap2_strobe | input | 1 | Capture 2 event |
| dbg_mode | input | 1 | Chip in debug mode |
| stop_mode | input | 1 | Chip in stop mode |
| reload_sel | input | 2 | Reload-on-capture source select |
| dbg_ctl | input | 2 | Debug action select (bit 0 halt, bit 1 force flag low) |
| stop_oe_off | input | 1 | Drop output enable in stop mode |
| out_invert | input | 1 | Output polarity invert |
| out_enable | input | 1 | Output enable request |
| load_val | input | W | Reload value |
| fifo1_pop | input | 1 | Pop capture 1 FIFO |
| fifo2_pop | input | 1 | Pop capture 2 FIFO |
| sts_clr | input | 4 | Write-1-to-clear status strobes |
| count | output | W | Counter value |
| fifo1_data | output | W | Oldest capture 1 word |
| fifo2_data | output | W | Oldest capture 2 word |
| fifo1_cnt | output | CW | Capture 1 FIFO word count |
| fifo2_cnt | output | CW | Capture 2 FIFO word count |
| out_pin | output | 1 | Output flag after polarity |
| out_oe | output | 1 | Output enable |
| sts | output | 4 | Sticky status: 0 wrap, 1 cap1, 2 cap2, 3 reload |

## Verification
The bench fires a strobe at a full FIFO. A design that let the word in would overwrite data or raise the count past the depth. It also makes a capture coincide with a reload, where a design that captured after loading would store load_val instead of the old count. Each reload_sel code is driven against the wrong capture input too, and a decoder with swapped bits would reload on that strobe. The debug force is checked with inversion on, where forcing the pin instead of the flag shows 0. A clear and a set are sent in the same cycle, and a design that let the clear win would lose the event.

// File: rtl/caprl_pkg.sv
package caprl_pkg;

    localparam int STS_W    = 4;
    localparam int STS_WRAP = 0;
    localparam int STS_CAP1 = 1;
    localparam int STS_CAP2 = 2;
    localparam int STS_RLD  = 3;

    typedef enum logic [1:0] {
        RLD_NONE = 2'b00,
        RLD_CAP1 = 2'b01,
        RLD_CAP2 = 2'b10,
        RLD_BOTH = 2'b11
    } reload_sel_e;

    typedef struct packed {
        logic halt;
        logic force_low;
    } dbg_act_t;

    function automatic logic reload_hit(input logic [1:0] sel,
                                        input logic c1, input logic c2);
        return (sel[0] & c1) | (sel[1] & c2);
    endfunction

    function automatic dbg_act_t dbg_decode(input logic in_dbg,
                                            input logic [1:0] ctl);
        dbg_act_t a;
        a.halt      = in_dbg & ctl[0];
        a.force_low = in_dbg & ctl[1];
        return a;
    endfunction

endpackage

// File: rtl/caprl_counter.sv
module caprl_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         count_en,
    input  logic         halt,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] MAXV = '1;

    logic step;
    assign step = count_en & ~halt & ~reload;
    assign wrap = step & (count == MAXV);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (reload)
            count <= load_val;
        else if (step)
            count <= count + W'(1);
    end
endmodule

// File: rtl/caprl_capfifo.sv
module caprl_capfifo #(
    parameter int W     = 16,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic          push_ok, pop_ok;
    logic [CW-1:0] wr_idx;

    assign pop_ok  = pop & (level != '0);
    assign push_ok = push & (level != CW'(DEPTH));
    assign wr_idx  = level - CW'(pop_ok);
    assign dout    = (level != '0) ? mem[0] : '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == DEPTH - 1) begin : g_last
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= '0;
                else if (push_ok && wr_idx == CW'(i))
                    mem[i] <= din;
                else if (pop_ok)
                    mem[i] <= '0;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= '0;
                else if (push_ok && wr_idx == CW'(i))
                    mem[i] <= din;
                else if (pop_ok)
                    mem[i] <= mem[i+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            level <= '0;
        else
            level <= level + CW'(push_ok) - CW'(pop_ok);
    end
endmodule

// File: rtl/caprl_status.sv
module caprl_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_w1,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & ~clr_w1) | set_ev;
    end
endmodule

// File: rtl/caprl_outflag.sv
module caprl_outflag (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    input  logic force_low,
    input  logic invert,
    input  logic oe_req,
    input  logic stop_mode,
    input  logic stop_oe_off,
    output logic pin,
    output logic oe
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (toggle)
            flag_q <= ~flag_q;
    end

    assign pin = (flag_q & ~force_low) ^ invert;
    assign oe  = oe_req & ~(stop_mode & stop_oe_off);
endmodule

// File: rtl/caprl_timer_chan.sv
module caprl_timer_chan
    import caprl_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             cap1_strobe,
    input  logic             cap2_strobe,
    input  logic             dbg_mode,
    input  logic             stop_mode,
    input  logic [1:0]       reload_sel,
    input  logic [1:0]       dbg_ctl,
    input  logic             stop_oe_off,
    input  logic             out_invert,
    input  logic             out_enable,
    input  logic [W-1:0]     load_val,
    input  logic             fifo1_pop,
    input  logic             fifo2_pop,
    input  logic [STS_W-1:0] sts_clr,
    output logic [W-1:0]     count,
    output logic [W-1:0]     fifo1_data,
    output logic [W-1:0]     fifo2_data,
    output logic [CW-1:0]    fifo1_cnt,
    output logic [CW-1:0]    fifo2_cnt,
    output logic             out_pin,
    output logic             out_oe,
    output logic [STS_W-1:0] sts
);
    dbg_act_t         act;
    logic             reload, wrap;
    logic [1:0]       cap_ev, cap_pop;
    logic [W-1:0]     cap_dout [2];
    logic [CW-1:0]    cap_lvl  [2];
    logic [STS_W-1:0] set_ev;

    assign act     = dbg_decode(dbg_mode, dbg_ctl);
    assign reload  = reload_hit(reload_sel, cap1_strobe, cap2_strobe);
    assign cap_ev  = {cap2_strobe, cap1_strobe};
    assign cap_pop = {fifo2_pop, fifo1_pop};

    caprl_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .count_en(count_en), .halt(act.halt),
        .reload(reload), .load_val(load_val), .count(count), .wrap(wrap)
    );

    for (genvar k = 0; k < 2; k++) begin : g_cap
        caprl_capfifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst(rst), .push(cap_ev[k]), .din(count),
            .pop(cap_pop[k]), .dout(cap_dout[k]), .level(cap_lvl[k])
        );
    end

    assign fifo1_data = cap_dout[0];
    assign fifo2_data = cap_dout[1];
    assign fifo1_cnt  = cap_lvl[0];
    assign fifo2_cnt  = cap_lvl[1];

    always_comb begin
        set_ev           = '0;
        set_ev[STS_WRAP] = wrap;
        set_ev[STS_CAP1] = cap1_strobe;
        set_ev[STS_CAP2] = cap2_strobe;
        set_ev[STS_RLD]  = reload;
    end

    caprl_status #(.N(STS_W)) u_sts (
        .clk(clk), .rst(rst), .set_ev(set_ev), .clr_w1(sts_clr), .flags(sts)
    );

    caprl_outflag u_out (
        .clk(clk), .rst(rst), .toggle(wrap), .force_low(act.force_low),
        .invert(out_invert), .oe_req(out_enable), .stop_mode(stop_mode),
        .stop_oe_off(stop_oe_off), .pin(out_pin), .oe(out_oe)
    );
endmodule

// File: rtl/caprl_timer_chan_chk.sv
module caprl_timer_chan_chk #(
    parameter int W  = 16,
    parameter int DEPTH = 2,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          count_en,
    input logic          cap1_strobe,
    input logic          cap2_strobe,
    input logic          dbg_mode,
    input logic          stop_mode,
    input logic [1:0]    reload_sel,
    input logic [1:0]    dbg_ctl,
    input logic          stop_oe_off,
    input logic          out_invert,
    input logic          out_enable,
    input logic [W-1:0]  load_val,
    input logic [W-1:0]  count,
    input logic [CW-1:0] fifo1_cnt,
    input logic [CW-1:0] fifo2_cnt,
    input logic          out_pin,
    input logic          out_oe,
    input logic [3:0]    sts
);
    logic rld_ev;
    assign rld_ev = (reload_sel[0] && cap1_strobe) || (reload_sel[1] && cap2_strobe);

    // R7
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        rld_ev |=> count == $past(load_val));

    // R9
    reload_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rld_ev |=> sts[3]);

    // R10
    debug_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && dbg_ctl[0] && !rld_ev) |=> $stable(count));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !rld_ev) |=> $stable(count));

    // R5
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo1_cnt <= CW'(DEPTH)) && (fifo2_cnt <= CW'(DEPTH)));

    // R11
    debug_force_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && dbg_ctl[1]) |-> out_pin == out_invert);

    // R12
    stop_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && stop_oe_off) |-> !out_oe);

    // R4
    cap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cap1_strobe || cap2_strobe) |=> (sts[1] || sts[2]));
endmodule

bind caprl_timer_chan caprl_timer_chan_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .count_en(count_en), .cap1_strobe(cap1_strobe),
    .cap2_strobe(cap2_strobe), .dbg_mode(dbg_mode), .stop_mode(stop_mode),
    .reload_sel(reload_sel), .dbg_ctl(dbg_ctl), .stop_oe_off(stop_oe_off),
    .out_invert(out_invert), .out_enable(out_enable), .load_val(load_val),
    .count(count), .fifo1_cnt(fifo1_cnt), .fifo2_cnt(fifo2_cnt),
    .out_pin(out_pin), .out_oe(out_oe), .sts(sts)
);

// File: tb/caprl_timer_chan_bench.sv
module caprl_timer_chan_bench;
    localparam int W  = 16;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          count_en = 0, cap1_strobe = 0, cap2_strobe = 0;
    logic          dbg_mode = 0, stop_mode = 0, stop_oe_off = 0;
    logic [1:0]    reload_sel = 2'b00, dbg_ctl = 2'b00;
    logic          out_invert = 0, out_enable = 1;
    logic [W-1:0]  load_val = '0;
    logic          fifo1_pop = 0, fifo2_pop = 0;
    logic [3:0]    sts_clr = '0;
    logic [W-1:0]  count, fifo1_data, fifo2_data;
    logic [CW-1:0] fifo1_cnt, fifo2_cnt;
    logic          out_pin, out_oe;
    logic [3:0]    sts;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    caprl_timer_chan u_caprl_timer_chan (
        .clk(clk), .rst(rst), .count_en(count_en), .cap1_strobe(cap1_strobe),
        .cap2_strobe(cap2_strobe), .dbg_mode(dbg_mode), .stop_mode(stop_mode),
        .reload_sel(reload_sel), .dbg_ctl(dbg_ctl), .stop_oe_off(stop_oe_off),
        .out_invert(out_invert), .out_enable(out_enable), .load_val(load_val),
        .fifo1_pop(fifo1_pop), .fifo2_pop(fifo2_pop), .sts_clr(sts_clr),
        .count(count), .fifo1_data(fifo1_data), .fifo2_data(fifo2_data),
        .fifo1_cnt(fifo1_cnt), .fifo2_cnt(fifo2_cnt), .out_pin(out_pin),
        .out_oe(out_oe), .sts(sts)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", 32'(count), 0);
        chk("R1 fifo1_cnt", 32'(fifo1_cnt), 0);
        chk("R1 fifo2_cnt", 32'(fifo2_cnt), 0);
        chk("R1 fifo1_data", 32'(fifo1_data), 0);
        chk("R1 sts", 32'(sts), 0);
        chk("R1 out_pin", 32'(out_pin), 0);
    endtask

    task automatic t_count();
        count_en = 1; tick(5); count_en = 0;
        chk("R2 count after 5", 32'(count), 5);
        tick(3);
        chk("R2 hold when disabled", 32'(count), 5);
    endtask

    task automatic t_capture();
        cap1_strobe = 1; tick(); cap1_strobe = 0;
        chk("R4 fifo1_cnt", 32'(fifo1_cnt), 1);
        chk("R4 fifo1_data", 32'(fifo1_data), 5);
        chk("R4 sts cap1", 32'(sts[1]), 1);
        chk("R4 fifo2 untouched", 32'(fifo2_cnt), 0);
        chk("R4 no reload with sel 00", 32'(count), 5);
        count_en = 1; tick(); count_en = 0;
        cap1_strobe = 1; tick();
        chk("R5 fifo1 full", 32'(fifo1_cnt), 2);
        fifo1_pop = 1; tick(); cap1_strobe = 0; fifo1_pop = 0;
        chk("R5 strobe at full dropped", 32'(fifo1_cnt), 1);
        chk("R6 oldest after pop", 32'(fifo1_data), 6);
        fifo1_pop = 1; tick(); fifo1_pop = 0;
        chk("R6 empty count", 32'(fifo1_cnt), 0);
        chk("R6 empty data zero", 32'(fifo1_data), 0);
        fifo1_pop = 1; tick(); fifo1_pop = 0;
        chk("R6 pop on empty", 32'(fifo1_cnt), 0);
    endtask

    task automatic t_reload();
        load_val = 16'h1234; reload_sel = 2'b01;
        cap2_strobe = 1; tick(); cap2_strobe = 0;
        chk("R7 sel 01 ignores cap2", 32'(count), 6);
        chk("R9 no reload flag", 32'(sts[3]), 0);
        chk("R4 fifo2 data", 32'(fifo2_data), 6);
        cap1_strobe = 1; tick(); cap1_strobe = 0;
        chk("R7 sel 01 reload", 32'(count), 32'h1234);
        chk("R8 pre-reload captured", 32'(fifo1_data), 6);
        chk("R9 reload flag", 32'(sts[3]), 1);
        reload_sel = 2'b10; load_val = 16'h0100;
        cap1_strobe = 1; tick(); cap1_strobe = 0;
        chk("R7 sel 10 ignores cap1", 32'(count), 32'h1234);
        cap2_strobe = 1; tick(); cap2_strobe = 0;
        chk("R7 sel 10 reload", 32'(count), 32'h0100);
        reload_sel = 2'b11; load_val = 16'h0055; count_en = 1;
        cap1_strobe = 1; tick(); cap1_strobe = 0; count_en = 0;
        chk("R7 sel 11 reload beats count", 32'(count), 32'h0055);
        chk("R5 full fifo1 keeps two", 32'(fifo1_cnt), 2);
        reload_sel = 2'b00;
        fifo1_pop = 1; fifo2_pop = 1; tick(2); fifo1_pop = 0; fifo2_pop = 0;
    endtask

    task automatic t_status();
        sts_clr = 4'hF; tick(); sts_clr = 4'h0;
        chk("R13 clear all", 32'(sts), 0);
        cap1_strobe = 1; sts_clr = 4'b0010; tick(); cap1_strobe = 0; sts_clr = 4'h0;
        chk("R13 set wins over clear", 32'(sts[1]), 1);
        sts_clr = 4'hF; tick(); sts_clr = 4'h0;
        fifo1_pop = 1; tick(); fifo1_pop = 0;
    endtask

    task automatic t_overflow();
        load_val = 16'hFFFE; reload_sel = 2'b01;
        cap1_strobe = 1; tick(); cap1_strobe = 0; reload_sel = 2'b00;
        fifo1_pop = 1; sts_clr = 4'hF; tick(); fifo1_pop = 0; sts_clr = 4'h0;
        count_en = 1; tick();
        chk("R3 at max", 32'(count), 32'hFFFF);
        chk("R3 no wrap yet", 32'(sts[0]), 0);
        tick(); count_en = 0;
        chk("R3 wrapped", 32'(count), 0);
        chk("R3 wrap flag", 32'(sts[0]), 1);
        chk("R3 flag toggled", 32'(out_pin), 1);
    endtask

    task automatic t_debug();
        dbg_mode = 1; dbg_ctl = 2'b00; count_en = 1; tick(2);
        chk("R10 ctl 00 counts", 32'(count), 2);
        chk("R10 ctl 00 pin", 32'(out_pin), 1);
        dbg_ctl = 2'b01; tick(3);
        chk("R10 halted", 32'(count), 2);
        dbg_ctl = 2'b10; #1;
        chk("R11 forced low", 32'(out_pin), 0);
        tick(2);
        chk("R11 force does not halt", 32'(count), 4);
        out_invert = 1; #1;
        chk("R11 force before invert", 32'(out_pin), 1);
        dbg_ctl = 2'b11; tick();
        chk("R10 ctl 11 halts", 32'(count), 4);
        out_invert = 0; #1;
        chk("R11 ctl 11 forces", 32'(out_pin), 0);
        dbg_mode = 0; #1;
        chk("R11 release", 32'(out_pin), 1);
        tick(); count_en = 0; dbg_ctl = 2'b00;
        chk("R10 leaves debug", 32'(count), 5);
    endtask

    task automatic t_stop();
        stop_mode = 1; stop_oe_off = 0; #1;
        chk("R12 bit clear keeps oe", 32'(out_oe), 1);
        stop_oe_off = 1; #1;
        chk("R12 stop drops oe", 32'(out_oe), 0);
        stop_mode = 0; #1;
        chk("R12 run restores oe", 32'(out_oe), 1);
        out_enable = 0; #1;
        chk("R12 follows out_enable", 32'(out_oe), 0);
        out_enable = 1; stop_oe_off = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 0;
        t_reset();
        t_count();
        t_capture();
        t_reload();
        t_status();
        t_overflow();
        t_debug();
        t_stop();
        finish_run();
    end
endmodule